// File: doc/BRIEF.md
# Conditional Skip Branch Unit

This block settles control flow for a small 8-bit processor whose only branch is a conditional skip. It takes a command byte, two 8-bit operands (called cache 0 and cache 1), the current program counter and a strobe. It tests the operands against the condition that the command encodes. It then returns the next program counter and the number of execution ticks the instruction used.

A skip command is recognised by command bits [6:3] equal to 0b0100, which gives the bases 0x20 and 0xA0. Bits [2:0] select the test. Bit 7 selects how the operands are read: as two's-complement values when it is clear, as unsigned values when it is set. A test that holds jumps over the next two 16-bit instructions. One that fails simply steps to the next instruction.

The operands, command and program counter are held stable while the strobe is high. The results are registered and appear one clock later, together with a single-cycle completion pulse.

Top module: `skip_branch_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, the done output is 0, next_pc is 0x00 and tick_count is 0.
- R2: A strobe is accepted only when command bits [6:3] equal 0b0100. With any other command, or with the strobe low, done stays 0 and next_pc and tick_count keep their previous values.
- R3: An accepted strobe raises done for exactly the following cycle. next_pc and tick_count are updated on that same cycle.
- R4: With bit 7 clear, the operands are compared as signed two's-complement values. The codes are: 1 is cache0 > cache1, 3 is >=, 4 is <, and 6 is <=.
- R5: With bit 7 set, codes 1, 3, 4 and 6 apply the same relations to the operands read as unsigned values.
- R6: Code 2 (equal) and code 5 (not equal) give the same outcome whatever the value of bit 7.
- R7: Code 0 never skips and code 7 always skips, whatever the value of bit 7 and the operands.
- R8: When the condition holds, next_pc is pc + 6 and tick_count is 3. When it does not, next_pc is pc + 2 and tick_count is 2.
- R9: next_pc is computed modulo 256. For example, 0xFC with a skip gives 0x02, and 0xFE with no skip gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Evaluate the presented command this cycle |
| cmd | input | 8 | Command byte |
| opnd0 | input | 8 | Cache 0 operand |
| opnd1 | input | 8 | Cache 1 operand |
| pc | input | 8 | Address of the current instruction |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 8 | Program counter after this instruction |
| tick_count | output | 2 | Execution ticks used by this instruction |

## Verification
A wrong internal decision shows up on the cycle right after the strobe. The program counter then moves by the wrong step, and the tick count disagrees with that step. So a single sample per strobe is enough to expose it. Operand pairs are chosen so that the signed and unsigned orderings disagree, for example 0x80 against 0x7F. With those pairs, swapping the signedness or mixing up two condition codes flips the outcome. A decode fault that accepts a foreign command shows up as a done pulse or a changed next_pc while none is expected.

// File: rtl/skb_pkg.sv
package skb_pkg;

    localparam int CMD_W = 8;
    localparam logic [3:0] SKIP_FAMILY = 4'b0100;

    typedef enum logic [2:0] {
        COND_NEVER  = 3'd0,
        COND_GT     = 3'd1,
        COND_EQ     = 3'd2,
        COND_GE     = 3'd3,
        COND_LT     = 3'd4,
        COND_NE     = 3'd5,
        COND_LE     = 3'd6,
        COND_ALWAYS = 3'd7
    } cond_e;

    typedef struct packed {
        logic  hit;
        logic  as_unsigned;
        cond_e cond;
    } decode_t;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } relation_t;

    function automatic logic cond_holds(cond_e c, relation_t r);
        logic res;
        unique case (c)
            COND_NEVER:  res = 1'b0;
            COND_GT:     res = r.gt;
            COND_EQ:     res = r.eq;
            COND_GE:     res = r.gt | r.eq;
            COND_LT:     res = r.lt;
            COND_NE:     res = ~r.eq;
            COND_LE:     res = r.lt | r.eq;
            COND_ALWAYS: res = 1'b1;
            default:     res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/skb_decode.sv
module skb_decode
    import skb_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output decode_t          dec
);
    always_comb begin
        dec.hit         = (cmd[6:3] == SKIP_FAMILY);
        dec.as_unsigned = cmd[7];
        dec.cond        = cond_e'(cmd[2:0]);
    end
endmodule

// File: rtl/skb_compare.sv
module skb_compare
    import skb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              as_unsigned,
    input  cond_e             cond,
    output logic              taken
);
    // One magnitude comparator serves both modes: flipping the sign bits
    // maps two's-complement order onto unsigned order.
    logic [DATA_W-1:0] a_k, b_k;
    relation_t         rel;

    always_comb begin
        a_k = a;
        b_k = b;
        if (!as_unsigned) begin
            a_k[DATA_W-1] = ~a[DATA_W-1];
            b_k[DATA_W-1] = ~b[DATA_W-1];
        end
        rel.gt = (a_k > b_k);
        rel.lt = (a_k < b_k);
        rel.eq = (a == b);
        taken  = cond_holds(cond, rel);
    end
endmodule

// File: rtl/skb_advance.sv
module skb_advance #(
    parameter int PC_W        = 8,
    parameter int TICK_W      = 2,
    parameter int INSTR_BYTES = 2,
    parameter int SKIP_INSTRS = 2,
    parameter int BASE_TICKS  = 2
) (
    input  logic [PC_W-1:0]   pc,
    input  logic              taken,
    output logic [PC_W-1:0]   pc_out,
    output logic [TICK_W-1:0] ticks
);
    localparam int STEP_PLAIN = INSTR_BYTES;
    localparam int STEP_SKIP  = INSTR_BYTES * (1 + SKIP_INSTRS);

    always_comb begin
        if (taken) begin
            pc_out = pc + PC_W'(STEP_SKIP);
            ticks  = TICK_W'(BASE_TICKS + 1);
        end else begin
            pc_out = pc + PC_W'(STEP_PLAIN);
            ticks  = TICK_W'(BASE_TICKS);
        end
    end
endmodule

// File: rtl/skip_branch_unit.sv
module skip_branch_unit
    import skb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PC_W   = 8,
    parameter int TICK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] opnd0,
    input  logic [DATA_W-1:0] opnd1,
    input  logic [PC_W-1:0]   pc,
    output logic              done,
    output logic [PC_W-1:0]   next_pc,
    output logic [TICK_W-1:0] tick_count
);
    decode_t           dec;
    logic              taken;
    logic [PC_W-1:0]   pc_calc;
    logic [TICK_W-1:0] ticks_calc;
    logic              accept;

    skb_decode u_dec (
        .cmd (cmd),
        .dec (dec)
    );

    skb_compare #(.DATA_W(DATA_W)) u_cmp (
        .a           (opnd0),
        .b           (opnd1),
        .as_unsigned (dec.as_unsigned),
        .cond        (dec.cond),
        .taken       (taken)
    );

    skb_advance #(.PC_W(PC_W), .TICK_W(TICK_W)) u_adv (
        .pc     (pc),
        .taken  (taken),
        .pc_out (pc_calc),
        .ticks  (ticks_calc)
    );

    assign accept = strobe & dec.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            next_pc    <= '0;
            tick_count <= '0;
        end else begin
            done <= accept;
            if (accept) begin
                next_pc    <= pc_calc;
                tick_count <= ticks_calc;
            end
        end
    end
endmodule

// File: rtl/skb_checker.sv
module skb_checker #(
    parameter int DATA_W = 8,
    parameter int PC_W   = 8,
    parameter int TICK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe,
    input logic [7:0]        cmd,
    input logic [DATA_W-1:0] opnd0,
    input logic [DATA_W-1:0] opnd1,
    input logic [PC_W-1:0]   pc,
    input logic              done,
    input logic [PC_W-1:0]   next_pc,
    input logic [TICK_W-1:0] tick_count
);
    logic fam;
    assign fam = (cmd[6:3] == 4'b0100);

    // R3
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(strobe && fam));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(strobe && fam) |=> (!done && $stable(next_pc) && $stable(tick_count)));

    // R8
    step_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((tick_count == TICK_W'(3) && next_pc == PC_W'($past(pc) + PC_W'(6))) ||
                  (tick_count == TICK_W'(2) && next_pc == PC_W'($past(pc) + PC_W'(2)))));

    // R7
    never_code_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(cmd[2:0]) == 3'd0) |-> tick_count == TICK_W'(2));

    // R7
    always_code_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(cmd[2:0]) == 3'd7) |-> tick_count == TICK_W'(3));

    // R6
    equal_code_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(cmd[2:0]) == 3'd2) |->
            ((tick_count == TICK_W'(3)) == ($past(opnd0) == $past(opnd1))));

    // R6
    unequal_code_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(cmd[2:0]) == 3'd5) |->
            ((tick_count == TICK_W'(3)) == ($past(opnd0) != $past(opnd1))));
endmodule

bind skip_branch_unit skb_checker #(
    .DATA_W (DATA_W),
    .PC_W   (PC_W),
    .TICK_W (TICK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .cmd        (cmd),
    .opnd0      (opnd0),
    .opnd1      (opnd1),
    .pc         (pc),
    .done       (done),
    .next_pc    (next_pc),
    .tick_count (tick_count)
);

// File: tb/skip_branch_unit_tb.sv
`timescale 1ns/1ps
module skip_branch_unit_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       strobe;
    logic [7:0] cmd, opnd0, opnd1, pc;
    logic       done;
    logic [7:0] next_pc;
    logic [1:0] tick_count;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    skip_branch_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .strobe     (strobe),
        .cmd        (cmd),
        .opnd0      (opnd0),
        .opnd1      (opnd1),
        .pc         (pc),
        .done       (done),
        .next_pc    (next_pc),
        .tick_count (tick_count)
    );

    // {cmd, cache0, cache1, pc, expected skip}
    localparam int NV = 22;
    localparam logic [32:0] VECS [NV] = '{
        {8'h21, 8'h05, 8'hFB, 8'h10, 1'b1},  // R4 5 > -5
        {8'hA1, 8'h05, 8'hFB, 8'h10, 1'b0},  // R5 5 > 251 false
        {8'h21, 8'h80, 8'h7F, 8'h20, 1'b0},  // R4 -128 > 127 false
        {8'hA1, 8'h80, 8'h7F, 8'h20, 1'b1},  // R5 128 > 127
        {8'h22, 8'h33, 8'h33, 8'h30, 1'b1},  // R6
        {8'hA2, 8'h33, 8'h34, 8'h30, 1'b0},  // R6
        {8'hA2, 8'h80, 8'h80, 8'h32, 1'b1},  // R6
        {8'h23, 8'hFF, 8'hFF, 8'h40, 1'b1},  // R4 ge equal
        {8'h23, 8'hFF, 8'h01, 8'h40, 1'b0},  // R4 -1 >= 1 false
        {8'hA3, 8'hFF, 8'h01, 8'h40, 1'b1},  // R5
        {8'h24, 8'hFF, 8'h01, 8'h50, 1'b1},  // R4 -1 < 1
        {8'hA4, 8'hFF, 8'h01, 8'h50, 1'b0},  // R5
        {8'h25, 8'h10, 8'h10, 8'h60, 1'b0},  // R6
        {8'hA5, 8'h10, 8'h11, 8'h60, 1'b1},  // R6
        {8'h26, 8'h80, 8'h80, 8'h70, 1'b1},  // R4 le equal
        {8'hA6, 8'h7F, 8'h80, 8'h70, 1'b1},  // R5 127 <= 128
        {8'h26, 8'h7F, 8'h80, 8'h70, 1'b0},  // R4 127 <= -128 false
        {8'h20, 8'h00, 8'h00, 8'h80, 1'b0},  // R7 never
        {8'hA0, 8'h05, 8'h06, 8'h80, 1'b0},  // R7 never
        {8'h27, 8'h03, 8'h09, 8'h90, 1'b1},  // R7 always
        {8'hA7, 8'h09, 8'h03, 8'hFC, 1'b1},  // R7 + R9 wrap to 0x02
        {8'h22, 8'h01, 8'h02, 8'hFE, 1'b0}   // R9 wrap to 0x00
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] p);
        @(negedge clk);
        cmd = c; opnd0 = a; opnd1 = b; pc = p; strobe = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic release_strobe();
        @(negedge clk);
        strobe = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] exp_pc;
        logic [1:0] exp_t;
        logic [7:0] held_pc;
        logic [1:0] held_t;
        rst = 1'b1; strobe = 1'b0; cmd = 8'h00; opnd0 = 8'h00; opnd1 = 8'h00; pc = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(done == 1'b0, "R1 done", 32'(done), 32'd0);
        check(next_pc == 8'h00, "R1 next_pc", 32'(next_pc), 32'd0);
        check(tick_count == 2'd0, "R1 ticks", 32'(tick_count), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(done == 1'b0, "R1 done after release", 32'(done), 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][32:25], VECS[i][24:17], VECS[i][16:9], VECS[i][8:1]);
            exp_pc = VECS[i][8:1] + (VECS[i][0] ? 8'd6 : 8'd2);
            exp_t  = VECS[i][0] ? 2'd3 : 2'd2;
            check(done == 1'b1, "R3 done pulse", 32'(done), 32'd1);
            check(next_pc == exp_pc, "R8 next_pc", 32'(next_pc), 32'(exp_pc));
            check(tick_count == exp_t, "R8 ticks", 32'(tick_count), 32'(exp_t));
            release_strobe();
            check(done == 1'b0, "R3 single-cycle done", 32'(done), 32'd0);
        end

        // R2: foreign commands are ignored and outputs hold
        held_pc = next_pc;
        held_t  = tick_count;
        foreach (VECS[k]) begin end
        for (int j = 0; j < 4; j++) begin
            logic [7:0] foreign;
            foreign = (j == 0) ? 8'h28 : (j == 1) ? 8'h08 : (j == 2) ? 8'h60 : 8'h00;
            apply(foreign, 8'h01, 8'h01, 8'h44);
            check(done == 1'b0, "R2 foreign done", 32'(done), 32'd0);
            check(next_pc == held_pc, "R2 foreign next_pc", 32'(next_pc), 32'(held_pc));
            check(tick_count == held_t, "R2 foreign ticks", 32'(tick_count), 32'(held_t));
        end
        release_strobe();

        // R2: family command without strobe is ignored
        @(negedge clk);
        cmd = 8'h27; pc = 8'h12; strobe = 1'b0;
        @(posedge clk);
        #1;
        check(done == 1'b0, "R2 no strobe done", 32'(done), 32'd0);
        check(next_pc == held_pc, "R2 no strobe next_pc", 32'(next_pc), 32'(held_pc));

        // R3: back-to-back strobes give one pulse each with fresh results
        apply(8'hA7, 8'h00, 8'h00, 8'h08);
        check(done && next_pc == 8'h0E, "R3 first of pair", 32'(next_pc), 32'h0E);
        apply(8'h20, 8'h00, 8'h00, 8'h0E);
        check(done && next_pc == 8'h10 && tick_count == 2'd2, "R3 second of pair",
              32'(next_pc), 32'h10);
        release_strobe();

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(next_pc == 8'h00 && tick_count == 2'd0 && !done, "R1 re-reset",
              32'(next_pc), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule